// File: doc/BRIEF.md
# Retriggerable Dual-Edge One-Shot Pulse Generator

This block produces a clean output pulse of a programmed number of clock cycles each time a qualified trigger edge arrives. A digital cycle counter sets the pulse length, so no external timing network is needed. Each channel has two trigger pins. One reacts to a rising edge while its partner pin is high. The other reacts to a falling edge while its partner pin is low. Both pins are first brought into the clock domain by a synchronizer. Edges are then detected on the synchronized levels, so a slow edge without glitches counts as one trigger.

Every accepted trigger opens a short lockout window of programmable length. Triggers inside that window are ignored. A trigger that arrives after the lockout but before the pulse ends restarts the full period. The single-shot input turns this off, so triggers are ignored while the output is high. Each channel has an active-low reset that drops the output at once. A power-on reset holds every channel quiet. The block contains a parameterized number of independent channels (two by default), each with complementary outputs.

Top module: `twin_oneshot`

## Requirements
- R1: A rising edge on `trig_a[i]` while `trig_b[i]` is high starts a pulse on `q[i]`. If the A level is applied before clock edge E0, `q[i]` is first high after edge E2. A rising edge on `trig_a[i]` while `trig_b[i]` is low is ignored.
- R2: A falling edge on `trig_b[i]` while `trig_a[i]` is low starts a pulse, with the same latency as R1. A falling edge on `trig_b[i]` while `trig_a[i]` is high is ignored.
- R3: `q[i]` rests low, and `qn[i]` is the inverse of `q[i]` in every cycle.
- R4: A single trigger holds `q[i]` high for exactly `period` cycles (1 or more), however long the trigger level stays active.
- R5: While `rst_n[i]` is low, `q[i]` is low and `qn[i]` is high from the moment `rst_n[i]` falls, without waiting for a clock edge. Triggers are ignored, and an interrupted pulse does not resume.
- R6: Raising `rst_n[i]` never starts a pulse, even when a trigger level is already present. A trigger whose accepting clock edge is the first edge with `rst_n[i]` high is taken: zero recovery time.
- R7: Take a second trigger level change that comes d cycles after the first. With d no greater than `lockout`, it falls in the lockout window and is ignored, and the pulse stays `period` cycles long.
- R8: With `single_shot` low and lockout+1 <= d <= period, the second trigger restarts the full period, and `q[i]` stays high for d+`period` cycles in total.
- R9: While `por_n` is low, every `q` is low and every `qn` is high, and trigger activity has no effect. Edge detection stays suppressed for the first cycles after release, until the synchronizers have filled.
- R10: Channels are independent: triggering or resetting one channel leaves the other channel's output unchanged.
- R11: With `single_shot` high, every trigger is ignored while `q[i]` is high, so the pulse is always exactly `period` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low, all channels |
| rst_n | input | NCH | Per-channel reset, active low |
| trig_a | input | NCH | Rising-edge trigger pins (qualified by trig_b high) |
| trig_b | input | NCH | Falling-edge trigger pins (qualified by trig_a low) |
| single_shot | input | 1 | 1 = non-retriggerable operation |
| period | input | CW | Pulse length in clock cycles |
| lockout | input | CW | Lockout window length in cycles, below period |
| q | output | NCH | True outputs, pulse high |
| qn | output | NCH | Inverted outputs |

## Verification
The bench builds the block with its defaults: two channels, an 8-bit count width and two synchronizer stages. It then sweeps `lockout` from 0 to 3 and `period` from lockout+1 to lockout+4. For every pair it tries every retrigger offset from 2 up to the period, in both retriggerable and single-shot modes. Because the widths are this small, the bench reaches every boundary: a retrigger one cycle inside the lockout, the first offset just past it, and the last offset that still lands on the final high cycle. It computes the expected high time arithmetically for each case. Reset release is probed on both sides of the accepting edge, and gating, channel isolation and power-on behaviour are each driven directly.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Internal events of one channel, brought out for checking.
  typedef struct packed {
    logic fire;     // qualified trigger edge seen this cycle
    logic accept;   // trigger taken by the timer
    logic in_lock;  // timer is inside its lockout window
    logic timeout;  // last high cycle of the pulse, no restart
  } os_evt_t;

  // Lockout is over once the elapsed count reaches the lockout length.
  function automatic logic os_lock_over(input logic [31:0] elapsed,
                                        input logic [31:0] lock_len);
    return elapsed >= lock_len;
  endfunction

  // The pulse ends after the cycle whose elapsed count is period-1.
  // A zero period behaves like a period of one.
  function automatic logic os_period_done(input logic [31:0] elapsed,
                                          input logic [31:0] period);
    return (elapsed + 32'd1) >= period;
  endfunction

endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) stage_q <= '0;
        else        stage_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) stage_q <= '0;
        else        stage_q <= {stage_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/os_trig_qual.sv
module os_trig_qual #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic a_s,
  input  logic b_s,
  output logic fire
);

  localparam int ARM_W = SYNC_STAGES + 1;

  logic             a_prev_q;
  logic             b_prev_q;
  logic [ARM_W-1:0] arm_q;
  logic             a_rise;
  logic             b_fall;
  logic             armed;

  // Previous levels keep running through channel reset, so a level that
  // is already present when reset is released never looks like an edge.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      a_prev_q <= 1'b0;
      b_prev_q <= 1'b0;
    end else begin
      a_prev_q <= a_s;
      b_prev_q <= b_s;
    end
  end

  // Suppress edges until the synchronizers and history hold real levels.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) arm_q <= '0;
    else        arm_q <= {arm_q[ARM_W-2:0], 1'b1};
  end

  assign armed  = arm_q[ARM_W-1];
  assign a_rise = a_s & ~a_prev_q & b_s;
  assign b_fall = b_prev_q & ~b_s & ~a_s;
  assign fire   = armed & (a_rise | b_fall);

endmodule

// File: rtl/os_timer.sv
module os_timer
  import oneshot_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          clr,
  input  logic          fire,
  input  logic          retrig_en,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] lockout,
  output logic          active,
  output os_evt_t       evt
);

  logic [CW-1:0] elapsed_q;
  logic          active_q;
  logic          in_lock;
  logic          can_take;
  logic          accept;
  logic          timeout;

  assign in_lock  = active_q & ~os_lock_over(32'(elapsed_q), 32'(lockout));
  assign can_take = ~active_q | (retrig_en & ~in_lock);
  assign accept   = fire & can_take;
  assign timeout  = active_q & ~accept & os_period_done(32'(elapsed_q), 32'(period));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      active_q  <= 1'b0;
      elapsed_q <= '0;
    end else if (clr) begin
      active_q  <= 1'b0;
      elapsed_q <= '0;
    end else if (accept) begin
      active_q  <= 1'b1;
      elapsed_q <= '0;
    end else if (timeout) begin
      active_q  <= 1'b0;
      elapsed_q <= '0;
    end else if (active_q) begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end

  assign active      = active_q;
  assign evt.fire    = fire;
  assign evt.accept  = accept;
  assign evt.in_lock = in_lock;
  assign evt.timeout = timeout;

endmodule

// File: rtl/os_channel.sv
module os_channel
  import oneshot_pkg::*;
#(
  parameter int CW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          trig_a,
  input  logic          trig_b,
  input  logic          single_shot,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] lockout,
  output logic          q,
  output logic          qn,
  output os_evt_t       evt
);

  logic a_s;
  logic b_s;
  logic fire;
  logic active;

  os_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk), .por_n(por_n), .din(trig_a), .dout(a_s)
  );

  os_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk), .por_n(por_n), .din(trig_b), .dout(b_s)
  );

  os_trig_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
    .clk(clk), .por_n(por_n), .a_s(a_s), .b_s(b_s), .fire(fire)
  );

  os_timer #(.CW(CW)) u_timer (
    .clk       (clk),
    .por_n     (por_n),
    .clr       (~rst_n),
    .fire      (fire),
    .retrig_en (~single_shot),
    .period    (period),
    .lockout   (lockout),
    .active    (active),
    .evt       (evt)
  );

  // Reset drops the output without waiting for a clock edge.
  assign q  = active & rst_n;
  assign qn = ~q;

endmodule

// File: rtl/twin_oneshot.sv
module twin_oneshot
  import oneshot_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int CW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic [NCH-1:0] rst_n,
  input  logic [NCH-1:0] trig_a,
  input  logic [NCH-1:0] trig_b,
  input  logic           single_shot,
  input  logic [CW-1:0]  period,
  input  logic [CW-1:0]  lockout,
  output logic [NCH-1:0] q,
  output logic [NCH-1:0] qn
);

  // Per-channel events flattened into vectors for the bound checker.
  logic [NCH-1:0] evt_fire;
  logic [NCH-1:0] evt_accept;
  logic [NCH-1:0] evt_lock;
  logic [NCH-1:0] evt_timeout;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      os_evt_t evt;

      os_channel #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) u_ch (
        .clk         (clk),
        .por_n       (por_n),
        .rst_n       (rst_n[c]),
        .trig_a      (trig_a[c]),
        .trig_b      (trig_b[c]),
        .single_shot (single_shot),
        .period      (period),
        .lockout     (lockout),
        .q           (q[c]),
        .qn          (qn[c]),
        .evt         (evt)
      );

      assign evt_fire[c]    = evt.fire;
      assign evt_accept[c]  = evt.accept;
      assign evt_lock[c]    = evt.in_lock;
      assign evt_timeout[c] = evt.timeout;
    end
  endgenerate

endmodule

// File: rtl/twin_oneshot_chk.sv
module twin_oneshot_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           por_n,
  input logic [NCH-1:0] rst_n,
  input logic           single_shot,
  input logic [NCH-1:0] q,
  input logic [NCH-1:0] fire,
  input logic [NCH-1:0] accept,
  input logic [NCH-1:0] in_lock,
  input logic [NCH-1:0] timeout
);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chk
      // R1: an output rise is always caused by a qualified edge
      a_r1_rise_from_fire: assert property (@(posedge clk) disable iff (!por_n)
        $rose(q[c]) |-> $past(fire[c]));

      // R4: outside reset, the output only falls after a timeout cycle
      a_r4_fall_on_timeout: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n[c] && $fell(q[c])) |-> $past(timeout[c]));

      // R5: a cycle spent in reset leaves the output low afterwards
      a_r5_reset_clears: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n[c] |=> !q[c]);

      // R7: nothing is accepted inside the lockout window
      a_r7_lock_blocks: assert property (@(posedge clk) disable iff (!por_n)
        (q[c] && in_lock[c]) |-> !accept[c]);

      // R8: an accepted retrigger keeps the output high
      a_r8_retrig_holds: assert property (@(posedge clk) disable iff (!por_n)
        (accept[c] && q[c]) |=> (q[c] || !rst_n[c]));

      // R11: single-shot mode takes no trigger while high
      a_r11_single_shot: assert property (@(posedge clk) disable iff (!por_n)
        (single_shot && q[c]) |-> !accept[c]);
    end
  endgenerate

endmodule

bind twin_oneshot twin_oneshot_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .rst_n       (rst_n),
  .single_shot (single_shot),
  .q           (q),
  .fire        (evt_fire),
  .accept      (evt_accept),
  .in_lock     (evt_lock),
  .timeout     (evt_timeout)
);

// File: tb/twin_oneshot_bench.sv
`timescale 1ns/1ps
module twin_oneshot_bench;
  localparam int NCH = 2;
  localparam int CW  = 8;

  logic           clk = 1'b0;
  logic           por_n;
  logic [NCH-1:0] rst_n;
  logic [NCH-1:0] trig_a;
  logic [NCH-1:0] trig_b;
  logic           single_shot;
  logic [CW-1:0]  period;
  logic [CW-1:0]  lockout;
  logic [NCH-1:0] q;
  logic [NCH-1:0] qn;

  int errs   = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  twin_oneshot u_twin_oneshot (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .trig_a(trig_a), .trig_b(trig_b),
    .single_shot(single_shot), .period(period), .lockout(lockout),
    .q(q), .qn(qn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic settle(input int n);
    repeat (n) tick;
  endtask

  // Count high samples per channel over n ticks without driving anything.
  task automatic count_high(input int n, output int h0, output int h1);
    h0 = 0; h1 = 0;
    for (int k = 0; k < n; k++) begin
      tick;
      if (q[0]) h0++;
      if (q[1]) h1++;
    end
  endtask

  // One-cycle A pulses on the masked channels at tick 0 and, if d > 0,
  // at tick d. High samples are counted at every later negedge.
  task automatic pulse_run(input logic [1:0] chm, input int d, input int win,
                           output int h0, output int h1);
    int bad;
    bad = 0; h0 = 0; h1 = 0;
    for (int k = 0; k <= win; k++) begin
      if (k > 0) begin
        if (q[0]) h0++;
        if (q[1]) h1++;
        if (qn !== ~q) bad++;
      end
      if (k == 0 || (d > 0 && k == d))     trig_a = trig_a | chm;
      if (k == 1 || (d > 0 && k == d + 1)) trig_a = trig_a & ~chm;
      tick;
    end
    chk(bad == 0, "R3 qn complements q", bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog (all) actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int h0, h1, exp;
    por_n = 1'b0; rst_n = 2'b11; trig_a = 2'b00; trig_b = 2'b11;
    single_shot = 1'b0; period = 8'd6; lockout = 8'd2;
    tick;

    // R9: power-on reset holds outputs quiet despite trigger activity
    for (int i = 0; i < 6; i++) begin
      trig_a = ~trig_a;
      tick;
      chk(q == 2'b00 && qn == 2'b11, "R9 outputs during power-on reset", int'(q), 0);
    end
    trig_a = 2'b00;
    settle(2);
    por_n = 1'b1;
    settle(8);
    chk(q == 2'b00, "R3 q rests low", int'(q), 0);
    chk(qn == 2'b11, "R3 qn rests high", int'(qn), 3);

    // R1: latency, first high after the second edge past sampling
    trig_a[0] = 1'b1; tick;
    trig_a[0] = 1'b0; tick;
    chk(q[0] == 1'b0, "R1 still low before E2", int'(q[0]), 0);
    tick;
    chk(q[0] == 1'b1, "R1 high after E2", int'(q[0]), 1);
    settle(12);

    // R4 / R7 / R8 / R11 sweep
    for (int m = 0; m < 2; m++) begin
      for (int lk = 0; lk < 4; lk++) begin
        for (int p = lk + 1; p <= lk + 4; p++) begin
          single_shot = m[0]; lockout = 8'(lk); period = 8'(p);
          tick;
          pulse_run(2'b01, 0, 2*p + 6, h0, h1);
          chk(h0 == p, "R4 single trigger width", h0, p);
          for (int d = 2; d <= p; d++) begin
            exp = (m == 0 && d >= lk + 1) ? d + p : p;
            pulse_run(2'b01, d, 2*p + 6, h0, h1);
            if (m == 1)           chk(h0 == exp, "R11 single-shot ignores retrigger", h0, exp);
            else if (d >= lk + 1) chk(h0 == exp, "R8 retrigger extends", h0, exp);
            else                  chk(h0 == exp, "R7 retrigger in lockout ignored", h0, exp);
          end
        end
      end
    end
    single_shot = 1'b0; period = 8'd6; lockout = 8'd2;
    tick;

    // R1: A rise with B low is ignored (B lowered under reset)
    rst_n[0] = 1'b0; trig_b[0] = 1'b0; settle(5); rst_n[0] = 1'b1; settle(2);
    pulse_run(2'b01, 0, 16, h0, h1);
    chk(h0 == 0, "R1 A rise while B low ignored", h0, 0);
    trig_b[0] = 1'b1; settle(4);

    // R2: B fall with A high is ignored (A raised under reset)
    rst_n[0] = 1'b0; trig_a[0] = 1'b1; settle(5); rst_n[0] = 1'b1; settle(2);
    trig_b[0] = 1'b0;
    count_high(16, h0, h1);
    chk(h0 == 0, "R2 B fall while A high ignored", h0, 0);
    rst_n[0] = 1'b0; trig_a[0] = 1'b0; trig_b[0] = 1'b1; settle(5); rst_n[0] = 1'b1; settle(2);

    // R2: B fall with A low triggers
    trig_b[0] = 1'b0;
    count_high(18, h0, h1);
    chk(h0 == 6, "R2 B fall while A low width", h0, 6);
    trig_b[0] = 1'b1; settle(4);

    // R4: long held trigger still gives one period
    trig_a[0] = 1'b1;
    count_high(20, h0, h1);
    chk(h0 == 6, "R4 width independent of hold", h0, 6);
    trig_a[0] = 1'b0; settle(6);

    // R5: reset mid-pulse drops output at once and nothing resumes
    trig_a[0] = 1'b1; tick; trig_a[0] = 1'b0; settle(3);
    chk(q[0] == 1'b1, "R5 pulse running before reset", int'(q[0]), 1);
    rst_n[0] = 1'b0;
    #1;
    chk(q[0] == 1'b0 && qn[0] == 1'b1, "R5 immediate reset of outputs", int'(q[0]), 0);
    tick; tick;
    rst_n[0] = 1'b1;
    count_high(14, h0, h1);
    chk(h0 == 0, "R5 no resume after reset", h0, 0);

    // R6: release just before the accepting edge is taken
    rst_n[0] = 1'b0; tick;
    trig_a[0] = 1'b1; tick;
    trig_a[0] = 1'b0; tick;
    rst_n[0] = 1'b1;
    count_high(14, h0, h1);
    chk(h0 == 6, "R6 zero recovery trigger accepted", h0, 6);

    // R6 / R5: release one cycle late, the trigger is lost
    rst_n[0] = 1'b0; tick;
    trig_a[0] = 1'b1; tick;
    trig_a[0] = 1'b0; tick; tick;
    rst_n[0] = 1'b1;
    count_high(14, h0, h1);
    chk(h0 == 0, "R5 trigger during reset ignored", h0, 0);

    // R6: releasing with A already high starts nothing
    rst_n[0] = 1'b0; trig_a[0] = 1'b1; settle(5);
    rst_n[0] = 1'b1;
    count_high(14, h0, h1);
    chk(h0 == 0, "R6 release with level present", h0, 0);
    trig_a[0] = 1'b0; settle(4);

    // R10: channel independence
    pulse_run(2'b10, 0, 18, h0, h1);
    chk(h0 == 0, "R10 channel 0 untouched by channel 1", h0, 0);
    chk(h1 == 6, "R10 channel 1 width", h1, 6);
    rst_n[1] = 1'b0;
    pulse_run(2'b11, 0, 18, h0, h1);
    chk(h0 == 6, "R10 channel 0 runs while channel 1 in reset", h0, 6);
    chk(h1 == 0, "R10 channel 1 held in reset", h1, 0);
    rst_n[1] = 1'b1; settle(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule